// File: doc/BRIEF.md
# Replayable Packet Slot Ring

This block sits between a 32-byte-wide packet stream and a transport engine that sends packets as send-with-immediate messages. Each complete inbound packet is copied into one slot of a power-of-two ring of packet buffers. The byte count up to the end-of-frame beat is recorded with the slot. For every filled slot the block raises one work request. The engine then fetches the payload with read requests that name the slot through the request ID. The block answers each read by replaying that slot's beats as a multi-beat response. The response is byte-swapped and carries first and last flags and byte enables. A replay never alters the slot, so a retried read returns the same bytes.

A slot comes back into use only when the engine reports a work completion for it, and completions release slots oldest first. When every slot is waiting for a completion, filling stops and the input stream is backpressured. This closes a flow-control loop paced by acknowledgements, with no credits kept in software. Frames longer than one slot (4096 bytes) are discarded up to their end-of-frame beat and counted. Completion outcomes are counted as well.

An enable input quiesces the whole datapath. Clearing it empties the ring, flushes any half-copied packet and returns every state machine to idle, so a restart needs no device reload. An elaboration check rejects a ring depth or a slot size that is not a power of two, and a slot capacity that does not fit the 13-bit length field.

Top module: `slot_ring`

## Requirements
- R1: After reset with enable high, wrValid and rspValid are low, inReady and rdReqReady are high, and all three counters read zero.
- R2: Each accepted frame of at most 128 beats produces exactly one work request, in fill order. The request has wrOpcode = 5'h03, wrRemAddr = 0 and wrRemKey = 0. wrId is the slot index, which starts at 0 after reset or re-enable and wraps modulo 16.
- R3: wrLen equals the number of set inKeep bits summed over all beats of the frame up to and including the beat with inLast. Inbound keep masks fill from lane 0. A full 128-beat frame gives 4096.
- R4: wrImm equals the slot index, zero-extended to 32 bits.
- R5: A read of slot s returns one response beat per stored beat, in order. rspFirst is set only on the first beat and rspLast only on the final beat. Byte i of rspData (bits 8i+7:8i) is stored byte 31-i, and rspByteEn[i] is stored keep bit 31-i. rspValid is low on the cycle after the final beat is taken.
- R6: Reading the same slot again returns byte-identical data, enables and flags.
- R7: When 16 slots hold frames that have not been completed, inReady is low and no further frame is taken.
- R8: Each completion frees the oldest dispatched slot. After one completion on a full ring, exactly one new frame is accepted, into the freed slot. The other slots keep their contents.
- R9: A frame longer than 128 beats gives no work request. Its beats are consumed up to inLast, oversizeCount increments by one, and the next frame is taken normally. cntClear zeroes oversizeCount.
- R10: A completion with an outstanding slot increments okCount when compOk is 1 and failCount when compOk is 0. cntClear zeroes both counters.
- R11: While enable is low, inReady, wrValid and rdReqReady are low. On re-enable the ring is empty and a partially copied frame is discarded, so the next frame alone fills slot 0.
- R12: rspErr is high on a response beat only if that beat's stored keep is not all ones and the beat is not the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Datapath enable; low flushes and idles everything |
| cntClear | input | 1 | Clears the three counters |
| inValid | input | 1 | Inbound beat valid |
| inReady | output | 1 | Inbound beat accepted |
| inData | input | 256 | Inbound beat data |
| inKeep | input | 32 | Inbound byte valid mask |
| inLast | input | 1 | Inbound end-of-frame |
| wrValid | output | 1 | Work request valid |
| wrReady | input | 1 | Work request taken |
| wrOpcode | output | 5 | Request opcode (send with immediate) |
| wrId | output | 4 | Request ID (slot index) |
| wrLen | output | 13 | Packet length in bytes |
| wrImm | output | 32 | Immediate value (slot index) |
| wrRemAddr | output | 64 | Remote address, zero |
| wrRemKey | output | 32 | Remote key, zero |
| rdReqValid | input | 1 | Read request valid |
| rdReqReady | output | 1 | Read request taken |
| rdReqId | input | 4 | Slot to replay |
| rspValid | output | 1 | Response beat valid |
| rspReady | input | 1 | Response beat taken |
| rspData | output | 256 | Byte-swapped beat data |
| rspByteEn | output | 32 | Bit-reversed byte enables |
| rspFirst | output | 1 | First beat of response |
| rspLast | output | 1 | Final beat of response |
| rspErr | output | 1 | Partial beat that is not final |
| compValid | input | 1 | Work completion strobe |
| compOk | input | 1 | Completion status, 1 is success |
| okCount | output | 32 | Successful completions |
| failCount | output | 32 | Failed completions |
| oversizeCount | output | 32 | Dropped over-length frames |

## Verification
A wrong fill or dispatch pointer shows up on the first work request after the fault. That request carries a wrong wrId, wrImm or wrLen, or an extra or missing request appears against the frames sent. A wrong release pointer or full test shows within one frame time, through inReady staying high on a full ring or staying low after a completion. A corrupted slot table or an altered read path shows on the next replay: the beat count, the swapped bytes, the reversed enables or the error flag differ from the stored frame, and a second read of the same slot differs from the first. Failure to flush on disable shows on the first request after re-enable, as a slot index other than 0 or a length that includes the stale beats.

// File: rtl/slot_ring_pkg.sv
package slot_ring_pkg;

  typedef enum logic {
    FILL_COPY,
    FILL_DROP
  } fillState_e;

  typedef enum logic {
    SRV_IDLE,
    SRV_BUSY
  } srvState_e;

  // strobes from control to slot storage
  typedef struct packed {
    logic beatWe;   // write current inbound beat
    logic commit;   // record length / beat count for the slot
  } storeStrobe_t;

  localparam logic [4:0] OP_SEND_IMM = 5'h03;

endpackage

// File: rtl/slot_ring_store.sv
module slot_ring_store
  import slot_ring_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int MAX_BEATS  = 128,
  parameter int BEAT_BYTES = 32,
  parameter int LEN_W      = 13
) (
  input  logic                          clk,
  input  logic                          rst,
  input  storeStrobe_t                  strobe,
  input  logic [$clog2(SLOTS)-1:0]      fillSlot,
  input  logic [$clog2(MAX_BEATS)-1:0]  fillBeat,
  input  logic [BEAT_BYTES*8-1:0]       inData,
  input  logic [BEAT_BYTES-1:0]         inKeep,
  input  logic [LEN_W-1:0]              commitLen,
  input  logic [$clog2(MAX_BEATS):0]    commitBeats,
  input  logic [$clog2(SLOTS)-1:0]      dispSlot,
  output logic [LEN_W-1:0]              dispLen,
  input  logic [$clog2(SLOTS)-1:0]      rdSlot,
  input  logic [$clog2(MAX_BEATS)-1:0]  rdBeat,
  output logic                          rdLastBeat,
  output logic [BEAT_BYTES*8-1:0]       rspData,
  output logic [BEAT_BYTES-1:0]         rspByteEn,
  output logic                          rspFirst,
  output logic                          rspLast,
  output logic                          rspErr
);

  localparam int SW    = $clog2(SLOTS);
  localparam int BAW   = $clog2(MAX_BEATS);
  localparam int BIW   = BAW + 1;
  localparam int DW    = BEAT_BYTES * 8;
  localparam int DEPTH = SLOTS * MAX_BEATS;
  localparam int AW    = SW + BAW;

  logic [DW-1:0]         dataMem [DEPTH];
  logic [BEAT_BYTES-1:0] keepMem [DEPTH];
  logic [LEN_W-1:0]      lenTab  [SLOTS];
  logic [BIW-1:0]        beatTab [SLOTS];

  logic [AW-1:0]         wrAddr;
  logic [AW-1:0]         rdAddr;
  logic [DW-1:0]         rdWord;
  logic [BEAT_BYTES-1:0] rdKeep;

  assign wrAddr = {fillSlot, fillBeat};
  assign rdAddr = {rdSlot, rdBeat};

  always_ff @(posedge clk) begin
    if (strobe.beatWe) begin
      dataMem[wrAddr] <= inData;
      keepMem[wrAddr] <= inKeep;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) begin
        lenTab[i]  <= '0;
        beatTab[i] <= BIW'(1);
      end
    end else if (strobe.commit) begin
      lenTab[fillSlot]  <= commitLen;
      beatTab[fillSlot] <= commitBeats;
    end
  end

  assign dispLen    = lenTab[dispSlot];
  assign rdWord     = dataMem[rdAddr];
  assign rdKeep     = keepMem[rdAddr];
  assign rdLastBeat = ({1'b0, rdBeat} + BIW'(1)) == beatTab[rdSlot];

  // lane reversal: byte g of the response is stored byte (BEAT_BYTES-1-g)
  for (genvar g = 0; g < BEAT_BYTES; g++) begin : g_lane
    assign rspData[g*8 +: 8] = rdWord[(BEAT_BYTES-1-g)*8 +: 8];
    assign rspByteEn[g]      = rdKeep[BEAT_BYTES-1-g];
  end

  assign rspFirst = (rdBeat == '0);
  assign rspLast  = rdLastBeat;
  assign rspErr   = !rdLastBeat && (rdKeep != '1);

endmodule

// File: rtl/slot_ring_ctrl.sv
module slot_ring_ctrl
  import slot_ring_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int MAX_BEATS  = 128,
  parameter int BEAT_BYTES = 32,
  parameter int LEN_W      = 13,
  parameter int CNT_W      = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enable,
  input  logic                          cntClear,
  input  logic                          inValid,
  input  logic [BEAT_BYTES-1:0]         inKeep,
  input  logic                          inLast,
  output logic                          inReady,
  output storeStrobe_t                  strobe,
  output logic [$clog2(SLOTS)-1:0]      fillSlot,
  output logic [$clog2(MAX_BEATS)-1:0]  fillBeat,
  output logic [LEN_W-1:0]              commitLen,
  output logic [$clog2(MAX_BEATS):0]    commitBeats,
  output logic                          wrValid,
  input  logic                          wrReady,
  output logic [$clog2(SLOTS)-1:0]      dispSlot,
  input  logic                          rdReqValid,
  input  logic [$clog2(SLOTS)-1:0]      rdReqId,
  output logic                          rdReqReady,
  output logic                          rspValid,
  input  logic                          rspReady,
  output logic [$clog2(SLOTS)-1:0]      rdSlot,
  output logic [$clog2(MAX_BEATS)-1:0]  rdBeat,
  input  logic                          rdLastBeat,
  input  logic                          compValid,
  input  logic                          compOk,
  output logic [CNT_W-1:0]              okCount,
  output logic [CNT_W-1:0]              failCount,
  output logic [CNT_W-1:0]              oversizeCount
);

  localparam int SW  = $clog2(SLOTS);
  localparam int PW  = SW + 1;
  localparam int BAW = $clog2(MAX_BEATS);
  localparam int BIW = BAW + 1;
  localparam int KW  = $clog2(BEAT_BYTES + 1);

  // ring pointers carry one wrap bit
  logic [PW-1:0]    fillPtr, dispPtr, relPtr;
  logic [BIW-1:0]   beatCnt;
  logic [LEN_W-1:0] byteAcc;
  fillState_e       fillSt;
  srvState_e        srvSt;
  logic [SW-1:0]    srvSlot;
  logic [BAW-1:0]   srvBeat;

  logic          ringFull;
  logic          inFire;
  logic          overBeat;
  logic [KW-1:0] keepCnt;
  logic          wrFire;
  logic          compTake;
  logic          rdAccept;
  logic          rspFire;

  assign ringFull = (fillPtr[SW] != relPtr[SW]) && (fillPtr[SW-1:0] == relPtr[SW-1:0]);
  assign inReady  = enable && ((fillSt == FILL_DROP) || (beatCnt != '0) || !ringFull);
  assign inFire   = inValid && inReady;
  assign overBeat = (fillSt == FILL_COPY) && (beatCnt == BIW'(MAX_BEATS));
  assign keepCnt  = KW'($countones(inKeep));

  assign strobe.beatWe = inFire && (fillSt == FILL_COPY) && !overBeat;
  assign strobe.commit = strobe.beatWe && inLast;
  assign fillSlot      = fillPtr[SW-1:0];
  assign fillBeat      = beatCnt[BAW-1:0];
  assign commitLen     = byteAcc + LEN_W'(keepCnt);
  assign commitBeats   = beatCnt + BIW'(1);

  assign wrValid  = enable && (dispPtr != fillPtr);
  assign wrFire   = wrValid && wrReady;
  assign dispSlot = dispPtr[SW-1:0];
  assign compTake = compValid && enable && (relPtr != dispPtr);

  // fill state machine and ring pointers
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      fillSt  <= FILL_COPY;
      beatCnt <= '0;
      byteAcc <= '0;
      fillPtr <= '0;
      dispPtr <= '0;
      relPtr  <= '0;
    end else begin
      if (inFire) begin
        case (fillSt)
          FILL_COPY: begin
            if (overBeat) begin
              beatCnt <= '0;
              byteAcc <= '0;
              if (!inLast) fillSt <= FILL_DROP;
            end else if (inLast) begin
              beatCnt <= '0;
              byteAcc <= '0;
              fillPtr <= fillPtr + PW'(1);
            end else begin
              beatCnt <= beatCnt + BIW'(1);
              byteAcc <= commitLen;
            end
          end
          FILL_DROP: begin
            if (inLast) fillSt <= FILL_COPY;
          end
          default: fillSt <= FILL_COPY;
        endcase
      end
      if (wrFire)   dispPtr <= dispPtr + PW'(1);
      if (compTake) relPtr  <= relPtr + PW'(1);
    end
  end

  // read-only replay of an addressed slot
  assign rdReqReady = enable && (srvSt == SRV_IDLE);
  assign rdAccept   = rdReqValid && rdReqReady;
  assign rspValid   = enable && (srvSt == SRV_BUSY);
  assign rspFire    = rspValid && rspReady;
  assign rdSlot     = srvSlot;
  assign rdBeat     = srvBeat;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      srvSt   <= SRV_IDLE;
      srvSlot <= '0;
      srvBeat <= '0;
    end else if (rdAccept) begin
      srvSt   <= SRV_BUSY;
      srvSlot <= rdReqId;
      srvBeat <= '0;
    end else if (rspFire) begin
      if (rdLastBeat) begin
        srvSt   <= SRV_IDLE;
        srvBeat <= '0;
      end else begin
        srvBeat <= srvBeat + BAW'(1);
      end
    end
  end

  // completion and drop counters
  always_ff @(posedge clk) begin
    if (rst || cntClear) begin
      okCount       <= '0;
      failCount     <= '0;
      oversizeCount <= '0;
    end else begin
      if (compTake && compOk)  okCount   <= okCount + CNT_W'(1);
      if (compTake && !compOk) failCount <= failCount + CNT_W'(1);
      if (inFire && overBeat)  oversizeCount <= oversizeCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/slot_ring.sv
module slot_ring
  import slot_ring_pkg::*;
#(
  parameter int SLOTS      = 16,
  parameter int MAX_BEATS  = 128,
  parameter int BEAT_BYTES = 32,
  parameter int LEN_W      = 13,
  parameter int CNT_W      = 32,
  parameter int IMM_W      = 32,
  parameter int ADDR_W     = 64,
  parameter int KEY_W      = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic                         cntClear,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [BEAT_BYTES*8-1:0]      inData,
  input  logic [BEAT_BYTES-1:0]        inKeep,
  input  logic                         inLast,
  output logic                         wrValid,
  input  logic                         wrReady,
  output logic [4:0]                   wrOpcode,
  output logic [$clog2(SLOTS)-1:0]     wrId,
  output logic [LEN_W-1:0]             wrLen,
  output logic [IMM_W-1:0]             wrImm,
  output logic [ADDR_W-1:0]            wrRemAddr,
  output logic [KEY_W-1:0]             wrRemKey,
  input  logic                         rdReqValid,
  output logic                         rdReqReady,
  input  logic [$clog2(SLOTS)-1:0]     rdReqId,
  output logic                         rspValid,
  input  logic                         rspReady,
  output logic [BEAT_BYTES*8-1:0]      rspData,
  output logic [BEAT_BYTES-1:0]        rspByteEn,
  output logic                         rspFirst,
  output logic                         rspLast,
  output logic                         rspErr,
  input  logic                         compValid,
  input  logic                         compOk,
  output logic [CNT_W-1:0]             okCount,
  output logic [CNT_W-1:0]             failCount,
  output logic [CNT_W-1:0]             oversizeCount
);

  localparam int SW  = $clog2(SLOTS);
  localparam int BAW = $clog2(MAX_BEATS);

  if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
    $error("slot_ring: SLOTS must be a power of two of at least 2");
  end
  if (MAX_BEATS < 2 || (MAX_BEATS & (MAX_BEATS - 1)) != 0) begin : g_bad_beats
    $error("slot_ring: MAX_BEATS must be a power of two of at least 2");
  end
  if (MAX_BEATS * BEAT_BYTES >= (1 << LEN_W)) begin : g_bad_len
    $error("slot_ring: slot capacity does not fit the length field");
  end

  storeStrobe_t      strobe;
  logic [SW-1:0]     fillSlot;
  logic [BAW-1:0]    fillBeat;
  logic [LEN_W-1:0]  commitLen;
  logic [BAW:0]      commitBeats;
  logic [SW-1:0]     dispSlot;
  logic [LEN_W-1:0]  dispLen;
  logic [SW-1:0]     rdSlot;
  logic [BAW-1:0]    rdBeat;
  logic              rdLastBeat;

  slot_ring_ctrl #(
    .SLOTS(SLOTS), .MAX_BEATS(MAX_BEATS), .BEAT_BYTES(BEAT_BYTES),
    .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .enable(enable), .cntClear(cntClear),
    .inValid(inValid), .inKeep(inKeep), .inLast(inLast), .inReady(inReady),
    .strobe(strobe), .fillSlot(fillSlot), .fillBeat(fillBeat),
    .commitLen(commitLen), .commitBeats(commitBeats),
    .wrValid(wrValid), .wrReady(wrReady), .dispSlot(dispSlot),
    .rdReqValid(rdReqValid), .rdReqId(rdReqId), .rdReqReady(rdReqReady),
    .rspValid(rspValid), .rspReady(rspReady), .rdSlot(rdSlot), .rdBeat(rdBeat),
    .rdLastBeat(rdLastBeat), .compValid(compValid), .compOk(compOk),
    .okCount(okCount), .failCount(failCount), .oversizeCount(oversizeCount)
  );

  slot_ring_store #(
    .SLOTS(SLOTS), .MAX_BEATS(MAX_BEATS), .BEAT_BYTES(BEAT_BYTES), .LEN_W(LEN_W)
  ) store_i (
    .clk(clk), .rst(rst), .strobe(strobe), .fillSlot(fillSlot), .fillBeat(fillBeat),
    .inData(inData), .inKeep(inKeep), .commitLen(commitLen), .commitBeats(commitBeats),
    .dispSlot(dispSlot), .dispLen(dispLen), .rdSlot(rdSlot), .rdBeat(rdBeat),
    .rdLastBeat(rdLastBeat), .rspData(rspData), .rspByteEn(rspByteEn),
    .rspFirst(rspFirst), .rspLast(rspLast), .rspErr(rspErr)
  );

  assign wrOpcode  = OP_SEND_IMM;
  assign wrId      = dispSlot;
  assign wrLen     = dispLen;
  assign wrImm     = IMM_W'(dispSlot);
  assign wrRemAddr = '0;
  assign wrRemKey  = '0;

endmodule

// File: rtl/slot_ring_chk.sv
module slot_ring_chk #(
  parameter int CNT_W = 32,
  parameter int SW    = 4,
  parameter int LEN_W = 13,
  parameter int DW    = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             cntClear,
  input logic             wrValid,
  input logic             wrReady,
  input logic [SW-1:0]    wrId,
  input logic [LEN_W-1:0] wrLen,
  input logic             rspValid,
  input logic             rspReady,
  input logic             rspLast,
  input logic             rspFirst,
  input logic [DW-1:0]    rspData,
  input logic             compValid,
  input logic             compOk,
  input logic [CNT_W-1:0] okCount,
  input logic [CNT_W-1:0] failCount,
  input logic [CNT_W-1:0] oversizeCount
);

  // independent count of dispatched, not yet completed requests
  logic [7:0] outst;
  always_ff @(posedge clk) begin
    if (rst || !enable) outst <= '0;
    else outst <= outst + 8'(wrValid && wrReady) - 8'(compValid && (outst != 0));
  end

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !wrReady && enable) |=> (!enable || (wrValid && $stable(wrId) && $stable(wrLen))));

  // R5
  rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspReady && enable) |=>
      (!enable || (rspValid && $stable(rspData) && $stable(rspFirst) && $stable(rspLast))));

  // R5
  rsp_end_chk: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspReady && rspLast) |=> !rspValid);

  // R11
  reenable_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |-> (!wrValid && !rspValid));

  // R10
  ok_count_chk: assert property (@(posedge clk) disable iff (rst)
    (compValid && compOk && enable && outst != 0 && !cntClear) |=>
      (okCount == $past(okCount) + CNT_W'(1)));

  // R10
  fail_count_chk: assert property (@(posedge clk) disable iff (rst)
    (compValid && !compOk && enable && outst != 0 && !cntClear) |=>
      (failCount == $past(failCount) + CNT_W'(1)));

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    cntClear |=> (oversizeCount == '0 && okCount == '0 && failCount == '0));

endmodule

bind slot_ring slot_ring_chk #(
  .CNT_W(CNT_W), .SW($clog2(SLOTS)), .LEN_W(LEN_W), .DW(BEAT_BYTES*8)
) chk_i (
  .clk(clk), .rst(rst), .enable(enable), .cntClear(cntClear),
  .wrValid(wrValid), .wrReady(wrReady), .wrId(wrId), .wrLen(wrLen),
  .rspValid(rspValid), .rspReady(rspReady), .rspLast(rspLast), .rspFirst(rspFirst),
  .rspData(rspData), .compValid(compValid), .compOk(compOk),
  .okCount(okCount), .failCount(failCount), .oversizeCount(oversizeCount)
);

// File: tb/slot_ring_tb_top.sv
`timescale 1ns/1ps
module slot_ring_tb_top;

  localparam int SLOTS = 16;
  localparam int MAXB  = 128;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst, enable, cntClear;
  logic         inValid, inReady, inLast;
  logic [255:0] inData;
  logic [31:0]  inKeep;
  logic         wrValid, wrReady;
  logic [4:0]   wrOpcode;
  logic [3:0]   wrId;
  logic [12:0]  wrLen;
  logic [31:0]  wrImm;
  logic [63:0]  wrRemAddr;
  logic [31:0]  wrRemKey;
  logic         rdReqValid, rdReqReady;
  logic [3:0]   rdReqId;
  logic         rspValid, rspReady, rspFirst, rspLast, rspErr;
  logic [255:0] rspData;
  logic [31:0]  rspByteEn;
  logic         compValid, compOk;
  logic [31:0]  okCount, failCount, oversizeCount;

  slot_ring dut_i (
    .clk(clk), .rst(rst), .enable(enable), .cntClear(cntClear),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inKeep(inKeep), .inLast(inLast),
    .wrValid(wrValid), .wrReady(wrReady), .wrOpcode(wrOpcode), .wrId(wrId), .wrLen(wrLen),
    .wrImm(wrImm), .wrRemAddr(wrRemAddr), .wrRemKey(wrRemKey),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqId(rdReqId),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData), .rspByteEn(rspByteEn),
    .rspFirst(rspFirst), .rspLast(rspLast), .rspErr(rspErr),
    .compValid(compValid), .compOk(compOk),
    .okCount(okCount), .failCount(failCount), .oversizeCount(oversizeCount)
  );

  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    vecs++;
    if (!cond) begin
      errs++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] genByte(input int f, input int b, input int j);
    return 8'(f * 37 + b * 5 + j * 11 + 1);
  endfunction

  function automatic logic [255:0] beatData(input int f, input int b);
    logic [255:0] d;
    for (int j = 0; j < 32; j++) d[j*8 +: 8] = genByte(f, b, j);
    return d;
  endfunction

  function automatic logic [255:0] swapData(input int f, input int b);
    logic [255:0] d;
    for (int j = 0; j < 32; j++) d[j*8 +: 8] = genByte(f, b, 31 - j);
    return d;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] k);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = k[31 - i];
    return r;
  endfunction

  function automatic logic [31:0] keepOf(input int b, input int nb,
                                         input logic [31:0] k0, input logic [31:0] kl);
    if (b == nb - 1) return kl;
    if (b == 0) return k0;
    return 32'hFFFF_FFFF;
  endfunction

  // scoreboard of expected work requests
  typedef struct { int id; int len; } wrExp_t;
  wrExp_t wrQ[$];
  int nextId = 0;
  int slotFrame[SLOTS];
  int slotBeats[SLOTS];
  logic [31:0] slotK0[SLOTS];
  logic [31:0] slotKl[SLOTS];

  // monitor: one handshake per negedge with wrValid and wrReady both high
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (wrValid && wrReady) begin
        if (wrQ.size() == 0) begin
          chk(1'b0, "R2", "unexpected work request id", 256'(wrId), 0);
        end else begin
          wrExp_t e;
          e = wrQ.pop_front();
          chk(wrId == 4'(e.id) && wrOpcode == 5'h03 && wrRemAddr == 0 && wrRemKey == 0,
              "R2", "id/opcode/raddr/rkey", {wrId, wrOpcode, wrRemAddr, wrRemKey},
              {4'(e.id), 5'h03, 64'h0, 32'h0});
          chk(wrLen == 13'(e.len), "R3", "length", 256'(wrLen), 256'(e.len));
          chk(wrImm == 32'(e.id), "R4", "immediate", 256'(wrImm), 256'(e.id));
        end
      end
    end
  end

  task automatic driveBeat(input logic [255:0] d, input logic [31:0] k, input logic l);
    bit ok;
    do begin
      @(negedge clk);
      inValid = 1'b1; inData = d; inKeep = k; inLast = l;
      #1;
      ok = inReady;
      @(posedge clk);
    end while (!ok);
  endtask

  task automatic sendFrame(input int f, input int nb, input logic [31:0] k0, input logic [31:0] kl);
    int len;
    wrExp_t e;
    len = 0;
    for (int b = 0; b < nb; b++) len += $countones(keepOf(b, nb, k0, kl));
    if (nb <= MAXB) begin
      e.id = nextId; e.len = len;
      wrQ.push_back(e);
      slotFrame[nextId] = f; slotBeats[nextId] = nb;
      slotK0[nextId] = k0; slotKl[nextId] = kl;
      nextId = (nextId + 1) % SLOTS;
    end
    for (int b = 0; b < nb; b++) driveBeat(beatData(f, b), keepOf(b, nb, k0, kl), b == nb - 1);
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic readSlot(input int s, input string tag);
    bit ok;
    int nb;
    int f;
    logic [31:0] k;
    nb = slotBeats[s];
    f  = slotFrame[s];
    do begin
      @(negedge clk);
      rdReqValid = 1'b1; rdReqId = 4'(s);
      #1;
      ok = rdReqReady;
      @(posedge clk);
    end while (!ok);
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      rdReqValid = 1'b0;
      #2;
      k = keepOf(b, nb, slotK0[s], slotKl[s]);
      chk(rspValid && rspData == swapData(f, b), tag, "response data", rspData, swapData(f, b));
      chk(rspByteEn == rev32(k) && rspFirst == (b == 0) && rspLast == (b == nb - 1), tag,
          "byteEn/first/last", {rspByteEn, rspFirst, rspLast}, {rev32(k), b == 0, b == nb - 1});
      chk(rspErr == (k != 32'hFFFF_FFFF && b != nb - 1), "R12", "partial beat flag",
          256'(rspErr), 256'(k != 32'hFFFF_FFFF && b != nb - 1));
    end
    @(negedge clk);
    #2;
    chk(!rspValid, tag, "idle after final beat", 256'(rspValid), 0);
  endtask

  task automatic complete(input logic ok);
    @(negedge clk);
    compValid = 1'b1; compOk = ok;
    @(negedge clk);
    compValid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b1; cntClear = 1'b0;
    inValid = 1'b0; inData = '0; inKeep = '0; inLast = 1'b0;
    wrReady = 1'b1; rdReqValid = 1'b0; rdReqId = '0; rspReady = 1'b1;
    compValid = 1'b0; compOk = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(!wrValid && !rspValid && inReady && rdReqReady, "R1", "handshake outputs",
        {wrValid, rspValid, inReady, rdReqReady}, 4'b0011);
    chk(okCount == 0 && failCount == 0 && oversizeCount == 0, "R1", "counters",
        {okCount, failCount, oversizeCount}, 0);

    // R2 R3 R4: several frame shapes
    sendFrame(1, 3, 32'hFFFF_FFFF, 32'h0000_001F);   // slot 0, 69 bytes
    sendFrame(2, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // slot 1, 32 bytes
    sendFrame(3, 128, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // slot 2, 4096 bytes (R3 cap)
    sendFrame(4, 2, 32'h0000_FFFF, 32'hFFFF_FFFF);   // slot 3, partial non-final beat

    // R5 R6 R12 replay
    readSlot(0, "R5");
    readSlot(0, "R6");
    readSlot(2, "R5");
    readSlot(3, "R12");
    readSlot(3, "R6");

    // R9 oversize frame dropped, next frame reframes
    sendFrame(5, 130, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    #1;
    chk(oversizeCount == 1, "R9", "oversize count", 256'(oversizeCount), 1);
    sendFrame(6, 1, 32'hFFFF_FFFF, 32'h0000_0003);   // slot 4

    // R10 completion counters (frees slots 0,1,2)
    complete(1'b1);
    complete(1'b1);
    complete(1'b0);
    #1;
    chk(okCount == 2 && failCount == 1, "R10", "ok/fail counts", {okCount, failCount}, {32'd2, 32'd1});

    // R7 fill the ring: 14 more frames make 16 outstanding
    for (int i = 0; i < 14; i++) sendFrame(10 + i, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = beatData(40, 0); inKeep = '1; inLast = 1'b1;
      #1;
      chk(!inReady, "R7", "input stalled on full ring", 256'(inReady), 0);
    end
    @(negedge clk);
    inValid = 1'b0;

    // R8 one completion frees the oldest slot (3); one frame goes in
    complete(1'b1);
    #1;
    chk(inReady, "R8", "input resumes after completion", 256'(inReady), 1);
    sendFrame(41, 2, 32'hFFFF_FFFF, 32'h0000_00FF);  // lands in slot 3
    repeat (3) @(negedge clk);
    inValid = 1'b1; inData = beatData(42, 0); inKeep = '1; inLast = 1'b1;
    #1;
    chk(!inReady, "R8", "ring full again after one frame", 256'(inReady), 0);
    @(negedge clk);
    inValid = 1'b0;
    readSlot(3, "R8");
    readSlot(4, "R8");

    // R10 R9 counter clear
    @(negedge clk);
    cntClear = 1'b1;
    @(negedge clk);
    cntClear = 1'b0;
    #1;
    chk(okCount == 0 && failCount == 0 && oversizeCount == 0, "R10", "counters cleared",
        {okCount, failCount, oversizeCount}, 0);
    chk(oversizeCount == 0, "R9", "oversize cleared", 256'(oversizeCount), 0);

    // R11 partial frame then disable / re-enable
    complete(1'b1);
    complete(1'b1);
    driveBeat(beatData(90, 0), '1, 1'b0);
    driveBeat(beatData(90, 1), '1, 1'b0);
    @(negedge clk);
    inValid = 1'b0;
    enable = 1'b0;
    #1;
    chk(!inReady && !wrValid && !rdReqReady, "R11", "quiet while disabled",
        {inReady, wrValid, rdReqReady}, 0);
    repeat (3) @(negedge clk);
    chk(wrQ.size() == 0, "R2", "all requests dispatched before disable", 256'(wrQ.size()), 0);
    enable = 1'b1;
    nextId = 0;
    sendFrame(91, 1, 32'hFFFF_FFFF, 32'h0000_000F); // slot 0, 4 bytes, no merge
    readSlot(0, "R11");

    repeat (10) @(negedge clk);
    chk(wrQ.size() == 0, "R2", "no request missing", 256'(wrQ.size()), 0);
    summary();
    $finish;
  end

endmodule